// File: doc/BRIEF.md
# Power Button Signal Stretcher

This block sits between a debounced push-button level and the active-low power-button line of a host chipset. The host starts a hardware forced-off countdown while that line is held low. So when the host is running, a press does not go through as one long low level. The line goes low for a short notification pulse, then goes high for a fixed gap, then goes low again for as long as the button stays down. The host's countdown restarts at the second assertion, so the hold time that forces a shutdown becomes roughly twice as long.

When the host is off, a press is stretched into a fixed wake pulse so that a quick tap still wakes the machine. Some pulses are generated by the block itself rather than by the button: a lid-open edge while the host is off, and a boot power-on request sampled during reset. The boot request waits for the power-allowed input, rechecks it periodically and gives up after a limit. A forced release input drops the line at once. A one-bit pulse-enable setting selects whether the short notification pulse is sent. All durations are counted in ticks of an external strobe, and the values are parameters.

Top module: `pwrbtn_stretch`

## Requirements
- R1: Reset holds `pwrbtn_n` high. After reset the block idles, unless `boot_req` was high during reset; in that case it enters the boot-wait state, whose first check falls on the first tick.
- R2: With the host on and pulse mode enabled, a press drives the line low for T0 ticks, then high for T1 ticks, then low until the button is released. A release in any of these phases returns the line high on the next clock.
- R3: With pulse mode disabled, a press while the host is on keeps the line high for T1 ticks and then drives it low until release.
- R4: If the host reports off when the T1 gap ends, the line stays high in the held phase until release.
- R5: A press while the host is off drives the line low for WAKE ticks. At the end of that pulse the line stays low if the button is still down, and goes high otherwise.
- R6: A rising edge of `lid_open` while the host is off, outside boot-wait, forces a WAKE-tick low pulse and then returns to idle with the line high. With the host on, the edge has no effect.
- R7: Button presses and releases are ignored during the boot-wait phase, the boot pulse, the lid pulse and the host-off wake pulse.
- R8: When the boot pulse ends or `force_rel` is asserted, the line goes high. If the button is down at that moment, its next release is swallowed without any change on the line, and a later press is handled normally.
- R9: In boot-wait, `pwr_ok` is checked every RETRY ticks. When it is high, a WAKE-tick low pulse is issued. Once BOOT_LIMIT ticks have elapsed since reset, a check returns the block to idle instead.
- R10: Pulse mode resets to enabled. `cfg_wr` loads it from `cfg_pulse_en`. `host_evt` forces it to enabled and wins over a simultaneous write.
- R11: While `host_off` is high and `pwr_ok` is low, the line is held high whatever the state.
- R12: Timed phases advance only on clock cycles where `tick` is high. With `tick` low, no timed phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_down | input | 1 | Debounced button level, 1 = pressed |
| host_off | input | 1 | Host chipset reports an off state |
| lid_open | input | 1 | Lid level, 1 = open; the rising edge is the event |
| pwr_ok | input | 1 | Power-on currently permitted |
| boot_req | input | 1 | Boot power-on request, sampled during reset |
| tick | input | 1 | Time-base strobe, one clock wide |
| force_rel | input | 1 | Forced release of the line |
| cfg_wr | input | 1 | Write strobe for the pulse-enable setting |
| cfg_pulse_en | input | 1 | Value written to the pulse-enable setting |
| host_evt | input | 1 | Host state transition strobe, re-enables pulse mode |
| pwrbtn_n | output | 1 | Active-low power-button line to the host |

## Verification
The bench runs the stretcher with long holds and short taps, both with the host on and with the host off. This separates the pulse, gap and re-assert sequence from the wake stretch, and shows that an early release ends the sequence. The host goes off in the middle of the gap, and the tick strobe is stopped in the middle of the gap; these runs separate the suppressed re-assert and the frozen timing from the normal path. Boot runs with power withheld, then granted, and with power withheld until the limit passes. Together with lid edges, forced releases and presses held across a forced pulse, these runs exercise the ignore and swallow rules on the release that follows.

// File: rtl/pwrbtn_pkg.sv
// Shared state encoding for the power button stretcher.
package pwrbtn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_T0         = 4'd1,
        ST_T1         = 4'd2,
        ST_HELD       = 4'd3,
        ST_EAT        = 4'd4,
        ST_WAS_OFF    = 4'd5,
        ST_LID        = 4'd6,
        ST_BOOT_WAIT  = 4'd7,
        ST_BOOT_PULSE = 4'd8
    } pb_state_e;

    // True for states in which button edges are discarded.
    function automatic logic edges_blocked(pb_state_e s);
        return (s == ST_WAS_OFF) || (s == ST_LID) ||
               (s == ST_BOOT_WAIT) || (s == ST_BOOT_PULSE);
    endfunction

endpackage

// File: rtl/pwrbtn_edge.sv
// Edge detector for a bundle of level inputs.
// Assumes the inputs are already synchronous to clk.
module pwrbtn_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] lvl_q;

    // Remember the previous level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    // One edge detector per input bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise[i] = lvl[i] & ~lvl_q[i];
        assign fall[i] = ~lvl[i] & lvl_q[i];
    end
endmodule

// File: rtl/pwrbtn_timer.sv
// Tick-driven down-counter. A load of N ends the phase after N ticks.
// A load of 0 disarms the counter. Assumes load values fit in CNT_W bits.
module pwrbtn_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_arm,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count down on ticks; a load overrides the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= rst_arm ? ONE : '0;
        else if (ld)                 cnt <= ld_val;
        else if (tick && cnt != '0)  cnt <= cnt - ONE;
    end

    // Expiry fires on the tick that consumes the last count.
    assign expire = tick && (cnt == ONE);
endmodule

// File: rtl/pwrbtn_uptime.sv
// Saturating tick counter measured from reset release.
// It flags when LIMIT ticks have elapsed.
module pwrbtn_uptime #(
    parameter int CNT_W = 32,
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic done
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);
    logic [CNT_W-1:0] cnt;

    // Count ticks until the limit, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (tick && !done)  cnt <= cnt + CNT_W'(1);
    end

    assign done = (cnt == LIM);
endmodule

// File: rtl/pwrbtn_cfg.sv
// Pulse-enable setting. Resets to enabled, and a host transition re-enables it.
module pwrbtn_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_pulse_en,
    input  logic host_evt,
    output logic pulse_en
);
    // Host transitions take priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)        pulse_en <= 1'b1;
        else if (host_evt) pulse_en <= 1'b1;
        else if (cfg_wr)   pulse_en <= cfg_pulse_en;
    end
endmodule

// File: rtl/pwrbtn_fsm.sv
// Sequencing state machine. It picks the next state, the registered drive
// level and the timer loads. Assumes the edge, expiry and limit inputs are
// all from the current cycle.
module pwrbtn_fsm
    import pwrbtn_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int T0_TICKS    = 32000,
    parameter int T1_TICKS    = 3968000,
    parameter int WAKE_TICKS  = 200000,
    parameter int RETRY_TICKS = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boot_req,
    input  logic             btn,
    input  logic             btn_rise,
    input  logic             btn_fall,
    input  logic             lid_rise,
    input  logic             host_off,
    input  logic             pwr_ok,
    input  logic             force_rel,
    input  logic             pulse_en,
    input  logic             tmr_exp,
    input  logic             boot_done,
    output pb_state_e        state_q,
    output logic             drive_lo,
    output logic             tmr_ld,
    output logic [CNT_W-1:0] tmr_val
);
    localparam logic [CNT_W-1:0] LD_T0    = CNT_W'(T0_TICKS);
    localparam logic [CNT_W-1:0] LD_T1    = CNT_W'(T1_TICKS);
    localparam logic [CNT_W-1:0] LD_WAKE  = CNT_W'(WAKE_TICKS);
    localparam logic [CNT_W-1:0] LD_RETRY = CNT_W'(RETRY_TICKS);

    pb_state_e st_n;
    logic      lo_n;

    // Next-state decision, in priority order: forced release, lid, then the rest.
    always_comb begin
        st_n    = state_q;
        lo_n    = drive_lo;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        if (force_rel) begin
            lo_n   = 1'b0;
            st_n   = btn ? ST_EAT : ST_IDLE;
            tmr_ld = 1'b1;
        end else if (lid_rise && host_off && state_q != ST_BOOT_WAIT) begin
            st_n    = ST_LID;
            lo_n    = 1'b1;
            tmr_ld  = 1'b1;
            tmr_val = LD_WAKE;
        end else if (edges_blocked(state_q)) begin
            if (tmr_exp) begin
                unique case (state_q)
                    ST_BOOT_WAIT: begin
                        if (boot_done) begin
                            st_n = ST_IDLE;
                        end else if (pwr_ok) begin
                            st_n    = ST_BOOT_PULSE;
                            lo_n    = 1'b1;
                            tmr_ld  = 1'b1;
                            tmr_val = LD_WAKE;
                        end else begin
                            tmr_ld  = 1'b1;
                            tmr_val = LD_RETRY;
                        end
                    end
                    ST_BOOT_PULSE: begin
                        lo_n = 1'b0;
                        st_n = btn ? ST_EAT : ST_IDLE;
                    end
                    ST_LID: begin
                        lo_n = 1'b0;
                        st_n = ST_IDLE;
                    end
                    default: begin
                        if (btn) begin
                            st_n = ST_HELD;
                        end else begin
                            st_n = ST_IDLE;
                            lo_n = 1'b0;
                        end
                    end
                endcase
            end
        end else if (btn_rise) begin
            tmr_ld = 1'b1;
            if (host_off) begin
                st_n    = ST_WAS_OFF;
                lo_n    = 1'b1;
                tmr_val = LD_WAKE;
            end else if (pulse_en) begin
                st_n    = ST_T0;
                lo_n    = 1'b1;
                tmr_val = LD_T0;
            end else begin
                st_n    = ST_T1;
                lo_n    = 1'b0;
                tmr_val = LD_T1;
            end
        end else if (btn_fall) begin
            st_n   = ST_IDLE;
            lo_n   = 1'b0;
            tmr_ld = 1'b1;
        end else if (tmr_exp) begin
            if (state_q == ST_T0) begin
                st_n    = ST_T1;
                lo_n    = 1'b0;
                tmr_ld  = 1'b1;
                tmr_val = LD_T1;
            end else if (state_q == ST_T1) begin
                st_n = ST_HELD;
                lo_n = !host_off;
            end
        end
    end

    // State and drive registers; the boot request is sampled during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= boot_req ? ST_BOOT_WAIT : ST_IDLE;
            drive_lo <= 1'b0;
        end else begin
            state_q  <= st_n;
            drive_lo <= lo_n;
        end
    end
endmodule

// File: rtl/pwrbtn_stretch.sv
// Top level of the power button stretcher. It joins the edge detector, the
// timer, the uptime limit, the pulse-enable setting and the FSM, and gates
// the line while power-on is not permitted. All inputs are synchronous.
module pwrbtn_stretch
    import pwrbtn_pkg::*;
#(
    parameter int CNT_W            = 32,
    parameter int T0_TICKS         = 32000,
    parameter int T1_TICKS         = 3968000,
    parameter int WAKE_TICKS       = 200000,
    parameter int RETRY_TICKS      = 100000,
    parameter int BOOT_LIMIT_TICKS = 8000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_down,
    input  logic host_off,
    input  logic lid_open,
    input  logic pwr_ok,
    input  logic boot_req,
    input  logic tick,
    input  logic force_rel,
    input  logic cfg_wr,
    input  logic cfg_pulse_en,
    input  logic host_evt,
    output logic pwrbtn_n
);
    localparam int EDGE_W = 2;

    logic [EDGE_W-1:0] lvl, rise, fall;
    logic              btn_rise, btn_fall, lid_rise;
    logic              tmr_exp, tmr_ld, boot_done, pulse_en, drive_lo;
    logic [CNT_W-1:0]  tmr_val, tmr_cnt;
    pb_state_e         state_q;
    logic              unused_fall;

    assign lvl         = {lid_open, btn_down};
    assign btn_rise    = rise[0];
    assign btn_fall    = fall[0];
    assign lid_rise    = rise[1];
    assign unused_fall = fall[1];

    pwrbtn_edge #(.W(EDGE_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise), .fall(fall)
    );

    pwrbtn_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .rst_arm(boot_req), .tick(tick),
        .ld(tmr_ld), .ld_val(tmr_val), .cnt(tmr_cnt), .expire(tmr_exp)
    );

    pwrbtn_uptime #(.CNT_W(CNT_W), .LIMIT(BOOT_LIMIT_TICKS)) u_uptime (
        .clk(clk), .rst_n(rst_n), .tick(tick), .done(boot_done)
    );

    pwrbtn_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pulse_en(cfg_pulse_en),
        .host_evt(host_evt), .pulse_en(pulse_en)
    );

    pwrbtn_fsm #(
        .CNT_W(CNT_W), .T0_TICKS(T0_TICKS), .T1_TICKS(T1_TICKS),
        .WAKE_TICKS(WAKE_TICKS), .RETRY_TICKS(RETRY_TICKS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .btn(btn_down),
        .btn_rise(btn_rise), .btn_fall(btn_fall), .lid_rise(lid_rise),
        .host_off(host_off), .pwr_ok(pwr_ok), .force_rel(force_rel),
        .pulse_en(pulse_en), .tmr_exp(tmr_exp), .boot_done(boot_done),
        .state_q(state_q), .drive_lo(drive_lo), .tmr_ld(tmr_ld),
        .tmr_val(tmr_val)
    );

    // Output gate: a host that is off with power withheld never sees a press.
    always_comb begin
        pwrbtn_n = !(drive_lo && !(host_off && !pwr_ok));
    end
endmodule

// File: rtl/pwrbtn_stretch_chk.sv
// Property checker for pwrbtn_stretch, bound to every instance of it.
module pwrbtn_stretch_chk
    import pwrbtn_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      pwrbtn_n,
    input logic      host_off,
    input logic      pwr_ok,
    input logic      tick,
    input logic      host_evt,
    input logic      force_rel,
    input logic      btn_rise,
    input logic      btn_fall,
    input logic      lid_rise,
    input logic      tmr_exp,
    input logic      pulse_en,
    input pb_state_e state_q
);
    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_EAT || state_q == ST_BOOT_WAIT) |-> pwrbtn_n);

    // R2
    gap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T1) |-> pwrbtn_n);

    // R11
    power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_off && !pwr_ok) |-> pwrbtn_n);

    // R7
    wake_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAS_OFF && !tmr_exp && !force_rel && !lid_rise)
        |=> (state_q == ST_WAS_OFF));

    // R10
    pulse_reenable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_evt |=> pulse_en);

    // R12
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !btn_rise && !btn_fall && !lid_rise && !force_rel)
        |=> $stable(state_q));
endmodule

bind pwrbtn_stretch pwrbtn_stretch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwrbtn_n(pwrbtn_n), .host_off(host_off),
    .pwr_ok(pwr_ok), .tick(tick), .host_evt(host_evt), .force_rel(force_rel),
    .btn_rise(btn_rise), .btn_fall(btn_fall), .lid_rise(lid_rise),
    .tmr_exp(tmr_exp), .pulse_en(pulse_en), .state_q(state_q)
);

// File: tb/pwrbtn_stretch_bench.sv
// Bench with a behavioural reference model, compared on every clock.
module pwrbtn_stretch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P_T0 = 4, P_T1 = 10, P_WAKE = 6, P_RETRY = 5, P_LIMIT = 40;

    // Model mode codes (bench-local).
    localparam int M_IDLE = 0, M_PULSE = 1, M_GAP = 2, M_HOLD = 3, M_SWALLOW = 4;
    localparam int M_WAKE = 5, M_LIDP = 6, M_BWAIT = 7, M_BPULSE = 8;

    logic clk = 0, rst_n = 0, btn_down = 0, host_off = 0, lid_open = 0;
    logic pwr_ok = 1, boot_req = 0, tick = 1, force_rel = 0;
    logic cfg_wr = 0, cfg_pulse_en = 0, host_evt = 0;
    logic pwrbtn_n;

    int checks = 0, errors = 0;
    string cur_req = "R1";

    int  m_mode, m_left, m_up;
    bit  m_low, m_pen, m_pbtn, m_plid;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrbtn_stretch #(
        .CNT_W(16), .T0_TICKS(P_T0), .T1_TICKS(P_T1), .WAKE_TICKS(P_WAKE),
        .RETRY_TICKS(P_RETRY), .BOOT_LIMIT_TICKS(P_LIMIT)
    ) u_pwrbtn_stretch (
        .clk(clk), .rst_n(rst_n), .btn_down(btn_down), .host_off(host_off),
        .lid_open(lid_open), .pwr_ok(pwr_ok), .boot_req(boot_req), .tick(tick),
        .force_rel(force_rel), .cfg_wr(cfg_wr), .cfg_pulse_en(cfg_pulse_en),
        .host_evt(host_evt), .pwrbtn_n(pwrbtn_n)
    );

    // Reference model of the requirements, advanced at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = boot_req ? M_BWAIT : M_IDLE;
            m_left = boot_req ? 1 : 0;
            m_up = 0; m_low = 0; m_pen = 1; m_pbtn = 0; m_plid = 0;
        end else begin
            bit up_edge, dn_edge, lid_edge, fin, limit_hit;
            int nleft;
            up_edge   = btn_down && !m_pbtn;
            dn_edge   = !btn_down && m_pbtn;
            lid_edge  = lid_open && !m_plid;
            fin       = (m_left == 1) && tick;
            limit_hit = (m_up >= P_LIMIT);
            nleft     = (tick && m_left > 0) ? m_left - 1 : m_left;
            if (force_rel) begin
                m_low = 0; m_mode = btn_down ? M_SWALLOW : M_IDLE; nleft = 0;
            end else if (lid_edge && host_off && m_mode != M_BWAIT) begin
                m_mode = M_LIDP; m_low = 1; nleft = P_WAKE;
            end else if (m_mode inside {M_WAKE, M_LIDP, M_BWAIT, M_BPULSE}) begin
                if (fin) begin
                    if (m_mode == M_BWAIT) begin
                        if (limit_hit) m_mode = M_IDLE;
                        else if (pwr_ok) begin m_mode = M_BPULSE; m_low = 1; nleft = P_WAKE; end
                        else nleft = P_RETRY;
                    end else if (m_mode == M_BPULSE) begin
                        m_low = 0; m_mode = btn_down ? M_SWALLOW : M_IDLE;
                    end else if (m_mode == M_LIDP) begin
                        m_low = 0; m_mode = M_IDLE;
                    end else begin
                        if (btn_down) m_mode = M_HOLD;
                        else begin m_mode = M_IDLE; m_low = 0; end
                    end
                end
            end else if (up_edge) begin
                if (host_off)   begin m_mode = M_WAKE;  m_low = 1; nleft = P_WAKE; end
                else if (m_pen) begin m_mode = M_PULSE; m_low = 1; nleft = P_T0; end
                else            begin m_mode = M_GAP;   m_low = 0; nleft = P_T1; end
            end else if (dn_edge) begin
                m_mode = M_IDLE; m_low = 0; nleft = 0;
            end else if (fin) begin
                if (m_mode == M_PULSE) begin m_mode = M_GAP; m_low = 0; nleft = P_T1; end
                else if (m_mode == M_GAP) begin m_mode = M_HOLD; m_low = !host_off; end
            end
            m_left = nleft;
            if (host_evt) m_pen = 1; else if (cfg_wr) m_pen = cfg_pulse_en;
            if (tick && m_up < P_LIMIT) m_up++;
            m_pbtn = btn_down; m_plid = lid_open;
        end
    end

    function automatic logic model_line();
        return !(m_low && !(host_off && !pwr_ok));
    endfunction

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            checks++;
            if (pwrbtn_n !== model_line()) begin
                errors++;
                $display("FAIL %s: pwrbtn_n=%0b expected %0b at %0t", cur_req, pwrbtn_n, model_line(), $time);
            end
        end
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pwrbtn_n=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(bit boot);
        rst_n = 0; boot_req = boot;
        step(3);
        rst_n = 1; boot_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 and R9: boot request with power withheld, then granted
        host_off = 1; pwr_ok = 0;
        do_reset(1);
        chk("R1", pwrbtn_n, 1'b1);
        cur_req = "R9"; step(14);
        pwr_ok = 1; step(3);
        cur_req = "R7"; btn_down = 1; step(12);
        cur_req = "R8"; btn_down = 0; step(4);
        // R9: give up after the limit
        pwr_ok = 0; do_reset(1);
        cur_req = "R9"; step(50);
        chk("R9", pwrbtn_n, 1'b1);
        // R2: normal long press with the host on
        do_reset(0); host_off = 0; pwr_ok = 1;
        cur_req = "R2"; btn_down = 1;
        step(1); chk("R2", pwrbtn_n, 1'b0);
        step(3); chk("R2", pwrbtn_n, 1'b0);
        step(1); chk("R2", pwrbtn_n, 1'b1);
        step(9); chk("R2", pwrbtn_n, 1'b1);
        step(1); chk("R2", pwrbtn_n, 1'b0);
        step(5); btn_down = 0;
        step(1); chk("R2", pwrbtn_n, 1'b1);
        step(3);
        // R12: tick stopped mid gap
        cur_req = "R12"; btn_down = 1; step(6);
        tick = 0; step(8); chk("R12", pwrbtn_n, 1'b1);
        tick = 1; step(12); btn_down = 0; step(3);
        // R3: pulse mode disabled
        cur_req = "R3"; cfg_wr = 1; cfg_pulse_en = 0; step(1); cfg_wr = 0;
        btn_down = 1; step(1); chk("R3", pwrbtn_n, 1'b1);
        step(12); btn_down = 0; step(2);
        // R10: host transition re-enables pulse mode
        cur_req = "R10"; host_evt = 1; step(1); host_evt = 0;
        btn_down = 1; step(1); chk("R10", pwrbtn_n, 1'b0);
        step(8); btn_down = 0; step(2);
        // R4: host goes off during the gap
        cur_req = "R4"; btn_down = 1; step(6); host_off = 1; step(14);
        chk("R4", pwrbtn_n, 1'b1);
        btn_down = 0; step(2);
        // R5: press with the host off, long then short
        cur_req = "R5"; btn_down = 1; step(1); chk("R5", pwrbtn_n, 1'b0);
        step(12); chk("R5", pwrbtn_n, 1'b0);
        btn_down = 0; step(1); chk("R5", pwrbtn_n, 1'b1); step(2);
        cur_req = "R7"; btn_down = 1; step(2); btn_down = 0; step(2);
        chk("R7", pwrbtn_n, 1'b0); step(5);
        // R6: lid open with host off, then with host on
        cur_req = "R6"; lid_open = 1; step(1); chk("R6", pwrbtn_n, 1'b0);
        step(8); lid_open = 0; step(1); host_off = 0;
        lid_open = 1; step(3); chk("R6", pwrbtn_n, 1'b1); lid_open = 0; step(1);
        // R11: power withheld while off
        cur_req = "R11"; host_off = 1; pwr_ok = 0; btn_down = 1;
        step(1); chk("R11", pwrbtn_n, 1'b1);
        step(10); btn_down = 0; step(8); pwr_ok = 1;
        // R8: forced release while held, swallowed release, fresh press
        cur_req = "R8"; host_off = 0; btn_down = 1; step(20);
        force_rel = 1; step(1); chk("R8", pwrbtn_n, 1'b1); force_rel = 0;
        step(3); btn_down = 0; step(1); chk("R8", pwrbtn_n, 1'b1);
        step(2); btn_down = 1; step(1); chk("R8", pwrbtn_n, 1'b0);
        step(5); btn_down = 0; step(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule